// File: doc/BRIEF.md
# Video Bus Address Decoder

This block sits behind the system bus and steers every access that falls in the video processor's region. The region is picked by the top address byte: only a request whose bits 31:24 are zero is claimed. Inside the region just the low 19 address bits are significant. That 512 KiB offset space is split into four kinds of target. Direct video RAM covers the bottom 256 KiB. An 8 KiB window is given to the register file. Two holes read as zero and drop writes. The top 32 KiB is a mirror that folds back onto four scattered 8 KiB character blocks inside video RAM.

The block is purely combinational. In the same cycle as the request it produces the target code, the RAM byte address (translated for the mirror), the little-endian byte-lane enables, the lane-placed write data, the register-file offset and strobes, and the read data muxed back from the selected target. The RAM array and the register contents live outside the block; only decoding, address translation and data steering are done here.

Top module: `vid_bus_decoder`

## Requirements
- R1: No enable is raised, `tgtSel` is 0 and `rdata` is 0 unless `reqValid` is high and `reqAddr[31:24]` is zero.
- R2: Only `reqAddr[18:0]` (the offset) affects decoding; bits 23:19 are ignored, so addresses differing only there decode identically.
- R3: Offsets 0x00000–0x3FFFF raise `ramEn`, set `tgtSel` = 1 and drive `ramAddr` equal to the offset.
- R4: Offsets 0x40000–0x5DFFF and 0x60000–0x77FFF raise no enable, set `tgtSel` = 0 and return `rdata` = 0 whatever the targets return.
- R5: Offsets 0x5E000–0x5FFFF raise `regEn`, set `tgtSel` = 2 and drive `regAddr` = offset − 0x5E000 (13 bits).
- R6: Offsets 0x78000–0x7FFFF raise `ramEn`, set `tgtSel` = 3 and drive `ramAddr` = 0x06000 + 0x8000·b + (offset mod 0x2000), where b is offset bits 14:13.
- R7: `ramWe` equals `ramEn` and `reqWrite`; `regWe` equals `regEn` and `reqWrite`; a read raises neither.
- R8: With `reqSize` 0 = byte, 1 = halfword, 2 or 3 = word, `ramByteEn` is 1 at lane offset[1:0] for a byte, 0b0011 shifted by 2·offset[1] for a halfword, and 0b1111 for a word (lane 0 = bits 7:0).
- R9: `ramWdata` carries the low byte/halfword/word of `reqWdata` placed at the lanes of R8, with all other lanes zero.
- R10: A RAM or mirror read returns in `rdata` the enabled lanes of `ramRdata` shifted down to bit 0 and zero-extended.
- R11: A register read returns `regRdata` unchanged; `regSize` and `regWdata` equal `reqSize` and `reqWdata`.
- R12: All outputs follow the inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Full system byte address |
| reqSize | input | 2 | 0 byte, 1 halfword, 2/3 word |
| reqWdata | input | 32 | Write data, low-aligned |
| ramRdata | input | 32 | Word read from video RAM at the word holding `ramAddr` |
| regRdata | input | 32 | Read value from the register file, already sized |
| tgtSel | output | 2 | 0 none, 1 RAM, 2 registers, 3 character mirror |
| ramEn | output | 1 | Video RAM access strobe |
| ramWe | output | 1 | Video RAM write strobe |
| ramAddr | output | 18 | Translated RAM byte address |
| ramByteEn | output | 4 | RAM byte-lane enables |
| ramWdata | output | 32 | Lane-placed RAM write data |
| regEn | output | 1 | Register-file access strobe |
| regWe | output | 1 | Register-file write strobe |
| regAddr | output | 13 | Byte offset inside the register window |
| regSize | output | 2 | Access size passed to the register file |
| regWdata | output | 32 | Write data passed to the register file |
| rdata | output | 32 | Read data returned to the bus |

## Verification
The checks assume every input is a settled, known value while they are evaluated, and that `reqSize` uses only its defined codes; the bench drives all inputs from a single task just after a rising edge and samples on the falling edge, so every evaluation sees a stable request. Mirror checks assume only offsets at or above 0x78000 carry `tgtSel` = 3, which the stimulus covers at both ends of the window and at each of the four banks. Unmapped-read checks load nonzero values on both read-data inputs so a leak would show.

// File: rtl/vdec_pkg.sv
`timescale 1ns/1ps
package vdec_pkg;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_RAM    = 2'd1,
    TGT_REG    = 2'd2,
    TGT_MIRROR = 2'd3
  } tgt_e;

  // Strobes handed from the decode control to the datapath
  typedef struct packed {
    logic ramHit;
    logic mirrorHit;
    logic regHit;
    logic writeOp;
  } strobe_t;

endpackage

// File: rtl/vdec_ctrl.sv
`timescale 1ns/1ps
module vdec_ctrl
  import vdec_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 8,
  parameter int OFF_W     = 19,
  parameter int RAM_TOP   = 'h40000,
  parameter int REG_BASE  = 'h5E000,
  parameter int REG_TOP   = 'h60000,
  parameter int MIR_BASE  = 'h78000
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output strobe_t           stb,
  output tgt_e              tgtSel,
  output logic              ramEn,
  output logic              ramWe,
  output logic              regEn,
  output logic              regWe
);

  localparam logic [OFF_W-1:0] RAM_TOP_O  = OFF_W'(RAM_TOP);
  localparam logic [OFF_W-1:0] REG_BASE_O = OFF_W'(REG_BASE);
  localparam logic [OFF_W-1:0] REG_TOP_O  = OFF_W'(REG_TOP);
  localparam logic [OFF_W-1:0] MIR_BASE_O = OFF_W'(MIR_BASE);

  logic             inRegion;
  logic [OFF_W-1:0] offset;

  assign inRegion = reqValid && (reqAddr[ADDR_W-1 -: TAG_W] == '0);
  assign offset   = reqAddr[OFF_W-1:0];

  always_comb begin
    stb       = '0;
    tgtSel    = TGT_NONE;
    if (inRegion) begin
      stb.writeOp = reqWrite;
      if (offset < RAM_TOP_O) begin
        stb.ramHit = 1'b1;
        tgtSel     = TGT_RAM;
      end else if (offset >= REG_BASE_O && offset < REG_TOP_O) begin
        stb.regHit = 1'b1;
        tgtSel     = TGT_REG;
      end else if (offset >= MIR_BASE_O) begin
        stb.mirrorHit = 1'b1;
        tgtSel        = TGT_MIRROR;
      end
    end
  end

  assign ramEn = stb.ramHit | stb.mirrorHit;
  assign ramWe = ramEn & stb.writeOp;
  assign regEn = stb.regHit;
  assign regWe = regEn & stb.writeOp;

endmodule

// File: rtl/vdec_path.sv
`timescale 1ns/1ps
module vdec_path
  import vdec_pkg::*;
#(
  parameter int OFF_W    = 19,
  parameter int RAM_AW   = 18,
  parameter int REG_AW   = 13,
  parameter int DATA_W   = 32,
  parameter int CHR_LSB  = 13,
  parameter int CHR_BASE = 'h06000
) (
  input  strobe_t           stb,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramRdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W/8-1:0] ramByteEn,
  output logic [DATA_W-1:0] ramWdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int BANK_SHIFT = CHR_LSB + 2;

  logic [LANE_W-1:0] lane;
  logic [LANE_W-1:0] shiftBytes;
  logic [LANE_W:0]   nBytes;
  logic [DATA_W-1:0] sizeMask;
  logic [LANE_W+2:0] shiftBits;
  logic [RAM_AW-1:0] mirAddr;

  assign lane = offset[LANE_W-1:0];

  // Character mirror: two bank bits move up two places, low bits pass
  assign mirAddr = RAM_AW'(CHR_BASE)
                 | (RAM_AW'(offset[CHR_LSB+1:CHR_LSB]) << BANK_SHIFT)
                 | RAM_AW'(offset[CHR_LSB-1:0]);

  assign ramAddr = stb.mirrorHit ? mirAddr : offset[RAM_AW-1:0];
  assign regAddr = offset[REG_AW-1:0];

  always_comb begin
    case (reqSize)
      2'd0: begin
        shiftBytes = lane;
        nBytes     = (LANE_W+1)'(1);
        sizeMask   = DATA_W'(8'hFF);
      end
      2'd1: begin
        shiftBytes = {lane[LANE_W-1:1], 1'b0};
        nBytes     = (LANE_W+1)'(2);
        sizeMask   = DATA_W'(16'hFFFF);
      end
      default: begin
        shiftBytes = '0;
        nBytes     = (LANE_W+1)'(LANES);
        sizeMask   = '1;
      end
    endcase
  end

  assign shiftBits = {shiftBytes, 3'b000};

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign ramByteEn[g] = (32'(shiftBytes) <= g) &&
                          (g < 32'(shiftBytes) + 32'(nBytes));
  end

  assign ramWdata = (reqWdata & sizeMask) << shiftBits;

  always_comb begin
    if (stb.ramHit || stb.mirrorHit)
      rdata = (ramRdata >> shiftBits) & sizeMask;
    else if (stb.regHit)
      rdata = regRdata;
    else
      rdata = '0;
  end

endmodule

// File: rtl/vid_bus_decoder.sv
`timescale 1ns/1ps
module vid_bus_decoder
  import vdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 19,
  parameter int RAM_AW = 18,
  parameter int REG_AW = 13
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramRdata,
  input  logic [DATA_W-1:0] regRdata,
  output logic [1:0]        tgtSel,
  output logic              ramEn,
  output logic              ramWe,
  output logic [RAM_AW-1:0] ramAddr,
  output logic [DATA_W/8-1:0] ramByteEn,
  output logic [DATA_W-1:0] ramWdata,
  output logic              regEn,
  output logic              regWe,
  output logic [REG_AW-1:0] regAddr,
  output logic [1:0]        regSize,
  output logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] rdata
);

  strobe_t stb;
  tgt_e    tgt;

  vdec_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ctrl (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .stb      (stb),
    .tgtSel   (tgt),
    .ramEn    (ramEn),
    .ramWe    (ramWe),
    .regEn    (regEn),
    .regWe    (regWe)
  );

  vdec_path #(.OFF_W(OFF_W), .RAM_AW(RAM_AW), .REG_AW(REG_AW), .DATA_W(DATA_W)) u_path (
    .stb       (stb),
    .offset    (reqAddr[OFF_W-1:0]),
    .reqSize   (reqSize),
    .reqWdata  (reqWdata),
    .ramRdata  (ramRdata),
    .regRdata  (regRdata),
    .ramAddr   (ramAddr),
    .regAddr   (regAddr),
    .ramByteEn (ramByteEn),
    .ramWdata  (ramWdata),
    .rdata     (rdata)
  );

  assign tgtSel   = tgt;
  assign regSize  = reqSize;
  assign regWdata = reqWdata;

endmodule

// File: rtl/vid_bus_decoder_chk.sv
`timescale 1ns/1ps
module vid_bus_decoder_chk (
  input logic        reqValid,
  input logic        reqWrite,
  input logic [31:0] reqAddr,
  input logic [1:0]  tgtSel,
  input logic        ramEn,
  input logic        ramWe,
  input logic [17:0] ramAddr,
  input logic [3:0]  ramByteEn,
  input logic        regEn,
  input logic        regWe,
  input logic [31:0] rdata
);

  always_comb begin
    // R1: nothing is claimed outside the region
    assert_region_R1: assert (!(reqValid == 1'b0 || reqAddr[31:24] != 8'h00) ||
                              (!ramEn && !regEn && tgtSel == 2'd0 && rdata == '0))
      else $error("R1 claim outside region");
    // R1: at most one target strobe
    assert_onehot_R1: assert ($onehot0({ramEn, regEn}))
      else $error("R1 two targets");
    // R4: unselected target reads as zero
    assert_unmapped_zero_R4: assert (!(tgtSel == 2'd0) || rdata == '0)
      else $error("R4 unmapped read not zero");
    // R6: mirror lands on a character block with offset bits kept
    assert_mirror_map_R6: assert (!(tgtSel == 2'd3) ||
                                  (ramAddr[14:13] == 2'b11 && ramAddr[12:0] == reqAddr[12:0]))
      else $error("R6 mirror address");
    // R7: write strobes only for writes to a selected target
    assert_write_gate_R7: assert ((!ramWe || (ramEn && reqWrite)) && (!regWe || (regEn && reqWrite)))
      else $error("R7 write strobe");
    // R8: lane enables cover 1, 2 or 4 lanes on a RAM access
    assert_lane_count_R8: assert (!ramEn || $countones(ramByteEn) == 1 ||
                                  $countones(ramByteEn) == 2 || $countones(ramByteEn) == 4)
      else $error("R8 lane count");
  end

endmodule

bind vid_bus_decoder vid_bus_decoder_chk u_chk (
  .reqValid  (reqValid),
  .reqWrite  (reqWrite),
  .reqAddr   (reqAddr),
  .tgtSel    (tgtSel),
  .ramEn     (ramEn),
  .ramWe     (ramWe),
  .ramAddr   (ramAddr),
  .ramByteEn (ramByteEn),
  .regEn     (regEn),
  .regWe     (regWe),
  .rdata     (rdata)
);

// File: tb/sim_vid_bus_decoder.sv
`timescale 1ns/1ps
module sim_vid_bus_decoder;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0, ramRdata = '0, regRdata = '0;
  logic [1:0]  reqSize = '0;
  logic [1:0]  tgtSel, regSize;
  logic        ramEn, ramWe, regEn, regWe;
  logic [17:0] ramAddr;
  logic [3:0]  ramByteEn;
  logic [31:0] ramWdata, regWdata, rdata;
  logic [12:0] regAddr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  vid_bus_decoder u0 (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .ramRdata(ramRdata), .regRdata(regRdata), .tgtSel(tgtSel),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramByteEn(ramByteEn),
    .ramWdata(ramWdata), .regEn(regEn), .regWe(regWe), .regAddr(regAddr),
    .regSize(regSize), .regWdata(regWdata), .rdata(rdata)
  );

  task automatic check(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic w, input logic [31:0] a, input logic [1:0] sz, input logic [31:0] wd);
    @(posedge clk);
    reqValid = v; reqWrite = w; reqAddr = a; reqSize = sz; reqWdata = wd;
    @(negedge clk);
  endtask

  task automatic testIdle();
    ramRdata = 32'h11223344; regRdata = 32'h55667788;
    drive(1'b0, 1'b0, 32'h0000_1000, 2'd2, '0);
    check("R1", "idle enables", {62'd0, ramEn, regEn}, 64'd0);
    check("R1", "idle rdata", rdata, 64'd0);
    drive(1'b1, 1'b1, 32'h0100_1000, 2'd2, 32'hFFFF_FFFF);
    check("R1", "other region enables", {60'd0, ramEn, regEn, ramWe, regWe}, 64'd0);
    check("R1", "other region tgt", tgtSel, 64'd0);
  endtask

  task automatic testRamRead();
    ramRdata = 32'hA1B2C3D4;
    drive(1'b1, 1'b0, 32'h0001_2345, 2'd0, '0);
    check("R3", "tgt", tgtSel, 64'd1);
    check("R3", "addr", ramAddr, 64'h12345);
    check("R8", "byte lanes", ramByteEn, 64'b0010);
    check("R10", "byte read", rdata, 64'hC3);
    check("R7", "read no we", {62'd0, ramWe, regWe}, 64'd0);
    drive(1'b1, 1'b0, 32'h0000_0002, 2'd1, '0);
    check("R10", "half read", rdata, 64'hA1B2);
    check("R8", "half lanes", ramByteEn, 64'b1100);
    drive(1'b1, 1'b0, 32'h0003_FFFC, 2'd2, '0);
    check("R10", "word read", rdata, 64'hA1B2C3D4);
    check("R8", "word lanes", ramByteEn, 64'b1111);
    drive(1'b1, 1'b0, 32'h0003_FFFF, 2'd0, '0);
    check("R3", "top of ram tgt", tgtSel, 64'd1);
    check("R10", "top byte", rdata, 64'hA1);
  endtask

  task automatic testAlias();
    drive(1'b1, 1'b0, 32'h00F1_2345, 2'd0, '0);
    check("R2", "alias tgt", tgtSel, 64'd1);
    check("R2", "alias addr", ramAddr, 64'h12345);
    drive(1'b1, 1'b0, 32'h00FD_E000, 2'd1, '0);
    check("R2", "alias reg", {63'd0, regEn}, 64'd1);
  endtask

  task automatic testRamWrite();
    drive(1'b1, 1'b1, 32'h0000_0103, 2'd0, 32'hFFFF_FFAB);
    check("R7", "byte we", {63'd0, ramWe}, 64'd1);
    check("R8", "byte lane 3", ramByteEn, 64'b1000);
    check("R9", "byte data", ramWdata, 64'hAB00_0000);
    drive(1'b1, 1'b1, 32'h0000_0102, 2'd1, 32'hDEAD_1234);
    check("R9", "half data", ramWdata, 64'h1234_0000);
    drive(1'b1, 1'b1, 32'h0000_0100, 2'd2, 32'hCAFE_F00D);
    check("R9", "word data", ramWdata, 64'hCAFE_F00D);
  endtask

  task automatic testUnmapped();
    logic [31:0] holes[4] = '{32'h0004_0000, 32'h0005_DFFF, 32'h0006_0000, 32'h0007_7FFF};
    ramRdata = 32'hFFFF_FFFF; regRdata = 32'hFFFF_FFFF;
    foreach (holes[i]) begin
      drive(1'b1, 1'b0, holes[i], 2'd2, '0);
      check("R4", "hole tgt", tgtSel, 64'd0);
      check("R4", "hole rdata", rdata, 64'd0);
      drive(1'b1, 1'b1, holes[i], 2'd2, 32'h1234_5678);
      check("R4", "hole write strobes", {60'd0, ramEn, regEn, ramWe, regWe}, 64'd0);
    end
  endtask

  task automatic testRegs();
    regRdata = 32'hCAFE_1234;
    drive(1'b1, 1'b0, 32'h0005_E000, 2'd1, '0);
    check("R5", "reg tgt", tgtSel, 64'd2);
    check("R5", "reg base addr", regAddr, 64'd0);
    check("R11", "reg rdata", rdata, 64'hCAFE_1234);
    check("R7", "reg read no we", {62'd0, regWe, ramEn}, 64'd0);
    drive(1'b1, 1'b1, 32'h0005_FFFE, 2'd0, 32'h0000_00C5);
    check("R5", "reg top addr", regAddr, 64'h1FFE);
    check("R7", "reg we", {62'd0, regWe, ramWe}, 64'b10);
    check("R11", "reg size/data", {30'd0, regSize, regWdata}, {30'd0, 2'd0, 32'h0000_00C5});
  endtask

  task automatic testMirror();
    logic [31:0] offs[6] = '{32'h78000, 32'h7A000, 32'h7C004, 32'h7E123, 32'h7FFFF, 32'h79ABC};
    ramRdata = 32'h0BAD_BEEF;
    foreach (offs[i]) begin
      int bank = (offs[i] - 32'h78000) / 32'h2000;
      int exp  = 32'h06000 + bank * 32'h8000 + (offs[i] % 32'h2000);
      drive(1'b1, 1'b0, offs[i], 2'd2, '0);
      check("R6", "mirror tgt", tgtSel, 64'd3);
      check("R6", "mirror addr", ramAddr, 64'(exp));
    end
    check("R10", "mirror word read", rdata, 64'h0BAD_BEEF);
  endtask

  task automatic testSameCycle();
    @(posedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 32'h0000_0010; reqSize = 2'd2;
    #1;
    check("R12", "ram tgt same cycle", tgtSel, 64'd1);
    reqAddr = 32'h0005_E010;
    #1;
    check("R12", "reg tgt same cycle", tgtSel, 64'd2);
    check("R12", "reg addr same cycle", regAddr, 64'h10);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testIdle();
    testRamRead();
    testAlias();
    testRamWrite();
    testUnmapped();
    testRegs();
    testMirror();
    testSameCycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule